// File: doc/BRIEF.md
# Dual-Width Data Block Transfer Counter

This block paces a block-oriented data transfer between a host register port and a one-unit holding slot that stands in for the card-side buffer. A host programs the port width, block length and block count through a small register window. It then starts a transfer in one direction. The host moves data through the port one unit at a time, 16 or 32 bits per access. The block counts bytes inside each block and counts the blocks of a multi-block transfer, and it marks the end of data with a one-cycle pulse.

There are two independent sets of length and count registers, one for each port width. The width chosen at the start of a transfer decides which set applies. The 16-bit set has a block-length ceiling of 512 bytes, while the 32-bit set accepts any 10-bit length. In 32-bit mode the count register itself runs down while the transfer proceeds, and two extra sticky flags record block completions. Receive-ready and transmit-request tell the host when it may access the port. Sticky overflow and underrun flags catch accesses made at the wrong time.

Top module: `dxfer_ctrl`

## Requirements
- R1: Bit 1 of the control register (select 0) picks the port width, 0 for 16-bit and 1 for 32-bit. It is read back on `wide_mode` and latched at `xfer_start`. Each counted access advances the byte count by 2 in 16-bit mode and by 4 in 32-bit mode.
- R2: A write to the 16-bit length register (select 1) keeps bits 9:0 of the data and stores 0x200 when that value exceeds 0x200.
- R3: A write to the 32-bit length register (select 3) stores bits 9:0 of the data unchanged, so values up to 0x3FF are kept.
- R4: In a multi-block 32-bit transfer, the 32-bit count register (select 4) drops by one at every completed block while it is nonzero. The 16-bit count register (select 2) is never altered by a transfer.
- R5: `rx_ready` is high exactly when a read transfer is busy and the slot holds a unit. `tx_req` is high exactly when a write transfer is busy and the slot is empty.
- R6: A host write while the slot is full sets sticky `ovf_flag` and leaves the slot contents unchanged. Writing the clear register (select 5) with bit 1 set resets the flag.
- R7: A host read while the slot is empty sets sticky `unf_flag`. The same clear bit (select 5, bit 1) resets it.
- R8: `aux_blk` is set at each block completion and `aux_end` at the final block, only in 32-bit mode and never in 16-bit mode. Writing the clear register with bit 0 set resets both.
- R9: A block of L bytes (after clipping) takes ceil(L/step) counted accesses, and one access when L is 0. `data_end` pulses for one cycle, in the cycle after the final access of the final block, and `busy` falls at the same time.
- R10: A single-block transfer (`xfer_multi`=0) ends after one block whatever the count registers hold, and it leaves both counts unchanged. A multi-block transfer with count 0 moves one block.
- R11: After reset, both length registers read 0x200, both counts read 0, the width bit is 0, and all flags, `busy` and `data_end` are 0.
- R12: In 16-bit mode, host writes keep only bits 15:0 of `host_wdata`, and `host_rdata` shows the slot with bits 31:16 forced to 0. In 32-bit mode all 32 bits pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select (0 control, 1 len16, 2 cnt16, 3 len32, 4 cnt32, 5 clear) |
| cfg_wdata | input | 16 | Register write data |
| xfer_start | input | 1 | Start a transfer (pulse) |
| xfer_read | input | 1 | Direction at start: 1 host reads, 0 host writes |
| xfer_multi | input | 1 | 1 multi-block, 0 single-block |
| host_rd | input | 1 | Host data-port read strobe |
| host_wr | input | 1 | Host data-port write strobe |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (masked per width) |
| card_push | input | 1 | Card side loads a unit into the slot |
| card_wdata | input | 32 | Card side load data |
| card_pop | input | 1 | Card side takes the unit from the slot |
| card_rdata | output | 32 | Slot contents toward the card side |
| wide_mode | output | 1 | Control register width bit |
| len16 | output | 10 | 16-bit block length register |
| len32 | output | 10 | 32-bit block length register |
| cnt16 | output | 16 | 16-bit block count register |
| cnt32 | output | 16 | 32-bit block count register (live) |
| busy | output | 1 | Transfer in progress |
| rx_ready | output | 1 | Host may read the port |
| tx_req | output | 1 | Host may write the port |
| data_end | output | 1 | One-cycle end-of-data pulse |
| ovf_flag | output | 1 | Sticky overflow flag |
| unf_flag | output | 1 | Sticky underrun flag |
| aux_blk | output | 1 | Sticky 32-bit block-completion flag |
| aux_end | output | 1 | Sticky 32-bit end-of-data flag |

## Verification
The assertions assume three things about the inputs. The card side loads the slot only when it is empty and drains it only when it is full. The count registers are not rewritten while a transfer is busy. A new start is never issued in the same cycle as a host access. The bench follows the handshake strictly: it loads before each host read and drains after each host write, and it programs all registers before the start pulse. It breaks the handshake on purpose only after the sweep has ended, when it provokes overflow and underrun with no transfer running.

// File: rtl/dxfer_pkg.sv
package dxfer_pkg;

    localparam int LEN_W  = 10;
    localparam int CNT_W  = 16;
    localparam int DATA_W = 32;
    localparam int REG_W  = 16;
    localparam int SEL_W  = 3;
    localparam logic [LEN_W-1:0] LEN16_CEIL = LEN_W'(10'h200);
    localparam logic [LEN_W-1:0] LEN_RESET  = LEN_W'(10'h200);
    localparam logic [DATA_W-1:0] HALF_MASK = DATA_W'({(DATA_W/2){1'b1}});

    typedef enum logic [SEL_W-1:0] {
        SEL_CTL   = 3'd0,
        SEL_LEN16 = 3'd1,
        SEL_CNT16 = 3'd2,
        SEL_LEN32 = 3'd3,
        SEL_CNT32 = 3'd4,
        SEL_CLR   = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic             wide;
        logic [LEN_W-1:0] len16;
        logic [LEN_W-1:0] len32;
        logic [CNT_W-1:0] cnt16;
        logic [CNT_W-1:0] cnt32;
    } cfg_t;

    typedef struct packed {
        logic             active;
        logic             rd;
        logic             multi;
        logic             wide;
        logic [LEN_W-1:0] len;
        logic [LEN_W:0]   bytes;
        logic [CNT_W-1:0] rem16;
    } seq_t;

    function automatic logic [LEN_W-1:0] clip_len16(input logic [REG_W-1:0] v);
        logic [LEN_W-1:0] low;
        low = v[LEN_W-1:0];
        return (low > LEN16_CEIL) ? LEN16_CEIL : low;
    endfunction

    function automatic logic [LEN_W:0] unit_bytes(input logic wide);
        return wide ? (LEN_W+1)'(4) : (LEN_W+1)'(2);
    endfunction

endpackage

// File: rtl/dxfer_regs.sv
module dxfer_regs
    import dxfer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [REG_W-1:0] cfg_wdata,
    input  logic             dec32,
    output cfg_t             cfg,
    output logic             clr_aux,
    output logic             clr_err
);

    reg_sel_e sel;
    assign sel = reg_sel_e'(cfg_sel);

    assign clr_aux = cfg_wr && (sel == SEL_CLR) && cfg_wdata[0];
    assign clr_err = cfg_wr && (sel == SEL_CLR) && cfg_wdata[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.wide  <= 1'b0;
            cfg.len16 <= LEN_RESET;
            cfg.len32 <= LEN_RESET;
            cfg.cnt16 <= '0;
            cfg.cnt32 <= '0;
        end else begin
            if (cfg_wr) begin
                case (sel)
                    SEL_CTL:   cfg.wide  <= cfg_wdata[1];
                    SEL_LEN16: cfg.len16 <= clip_len16(cfg_wdata);
                    SEL_CNT16: cfg.cnt16 <= cfg_wdata[CNT_W-1:0];
                    SEL_LEN32: cfg.len32 <= cfg_wdata[LEN_W-1:0];
                    default:   ;
                endcase
            end
            if (cfg_wr && (sel == SEL_CNT32)) begin
                cfg.cnt32 <= cfg_wdata[CNT_W-1:0];
            end else if (dec32) begin
                cfg.cnt32 <= cfg.cnt32 - CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/dxfer_slot.sv
module dxfer_slot
    import dxfer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              wide,
    input  logic              clr_err,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              card_push,
    input  logic [DATA_W-1:0] card_wdata,
    input  logic              card_pop,
    output logic [DATA_W-1:0] host_rdata,
    output logic [DATA_W-1:0] card_rdata,
    output logic              full,
    output logic              rd_take,
    output logic              wr_take,
    output logic              ovf,
    output logic              unf
);

    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] mask;

    assign mask       = wide ? {DATA_W{1'b1}} : HALF_MASK;
    assign rd_take    = host_rd && full;
    assign wr_take    = host_wr && !full;
    assign host_rdata = data_q & mask;
    assign card_rdata = data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            full   <= 1'b0;
            data_q <= '0;
        end else if (start) begin
            full <= 1'b0;
        end else if (rd_take) begin
            full <= 1'b0;
        end else if (wr_take) begin
            full   <= 1'b1;
            data_q <= host_wdata & mask;
        end else if (card_push && !full) begin
            full   <= 1'b1;
            data_q <= card_wdata;
        end else if (card_pop && full) begin
            full <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf <= 1'b0;
            unf <= 1'b0;
        end else begin
            if (host_wr && full)      ovf <= 1'b1;
            else if (clr_err)         ovf <= 1'b0;
            if (host_rd && !full)     unf <= 1'b1;
            else if (clr_err)         unf <= 1'b0;
        end
    end

endmodule

// File: rtl/dxfer_seq.sv
module dxfer_seq
    import dxfer_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cfg_t cfg,
    input  logic start,
    input  logic start_read,
    input  logic start_multi,
    input  logic rd_take,
    input  logic wr_take,
    input  logic clr_aux,
    output logic busy,
    output logic run_read,
    output logic run_wide,
    output logic data_end,
    output logic aux_blk,
    output logic aux_end,
    output logic dec32
);

    seq_t             st;
    logic             take;
    logic [LEN_W:0]   nxt;
    logic             blk_end;
    logic [CNT_W-1:0] remaining;
    logic             last_blk;

    always_comb begin
        take      = st.active && !start && (st.rd ? rd_take : wr_take);
        nxt       = st.bytes + unit_bytes(st.wide);
        blk_end   = take && (nxt >= {1'b0, st.len});
        remaining = st.wide ? cfg.cnt32 : st.rem16;
        last_blk  = !st.multi || (remaining <= CNT_W'(1));
        dec32     = blk_end && st.multi && st.wide && (cfg.cnt32 != '0);
    end

    assign busy     = st.active;
    assign run_read = st.rd;
    assign run_wide = st.wide;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= '0;
            data_end <= 1'b0;
        end else begin
            data_end <= 1'b0;
            if (start) begin
                st.active <= 1'b1;
                st.rd     <= start_read;
                st.multi  <= start_multi;
                st.wide   <= cfg.wide;
                st.len    <= cfg.wide ? cfg.len32 : cfg.len16;
                st.bytes  <= '0;
                st.rem16  <= cfg.cnt16;
            end else if (take) begin
                if (blk_end) begin
                    st.bytes <= '0;
                    if (!st.wide && st.multi && (st.rem16 != '0)) begin
                        st.rem16 <= st.rem16 - CNT_W'(1);
                    end
                    if (last_blk) begin
                        st.active <= 1'b0;
                        data_end  <= 1'b1;
                    end
                end else begin
                    st.bytes <= nxt;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            aux_blk <= 1'b0;
            aux_end <= 1'b0;
        end else begin
            if (blk_end && st.wide)                 aux_blk <= 1'b1;
            else if (clr_aux)                       aux_blk <= 1'b0;
            if (blk_end && last_blk && st.wide)     aux_end <= 1'b1;
            else if (clr_aux)                       aux_end <= 1'b0;
        end
    end

endmodule

// File: rtl/dxfer_ctrl.sv
module dxfer_ctrl
    import dxfer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic              xfer_start,
    input  logic              xfer_read,
    input  logic              xfer_multi,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              card_push,
    input  logic [DATA_W-1:0] card_wdata,
    input  logic              card_pop,
    output logic [DATA_W-1:0] card_rdata,
    output logic              wide_mode,
    output logic [LEN_W-1:0]  len16,
    output logic [LEN_W-1:0]  len32,
    output logic [CNT_W-1:0]  cnt16,
    output logic [CNT_W-1:0]  cnt32,
    output logic              busy,
    output logic              rx_ready,
    output logic              tx_req,
    output logic              data_end,
    output logic              ovf_flag,
    output logic              unf_flag,
    output logic              aux_blk,
    output logic              aux_end
);

    cfg_t cfg;
    logic clr_aux, clr_err, dec32;
    logic slot_full, rd_take, wr_take;
    logic run_read, run_wide;

    dxfer_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .dec32     (dec32),
        .cfg       (cfg),
        .clr_aux   (clr_aux),
        .clr_err   (clr_err)
    );

    dxfer_slot u_slot (
        .clk        (clk),
        .rst        (rst),
        .start      (xfer_start),
        .wide       (run_wide),
        .clr_err    (clr_err),
        .host_rd    (host_rd),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .card_push  (card_push),
        .card_wdata (card_wdata),
        .card_pop   (card_pop),
        .host_rdata (host_rdata),
        .card_rdata (card_rdata),
        .full       (slot_full),
        .rd_take    (rd_take),
        .wr_take    (wr_take),
        .ovf        (ovf_flag),
        .unf        (unf_flag)
    );

    dxfer_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .cfg         (cfg),
        .start       (xfer_start),
        .start_read  (xfer_read),
        .start_multi (xfer_multi),
        .rd_take     (rd_take),
        .wr_take     (wr_take),
        .clr_aux     (clr_aux),
        .busy        (busy),
        .run_read    (run_read),
        .run_wide    (run_wide),
        .data_end    (data_end),
        .aux_blk     (aux_blk),
        .aux_end     (aux_end),
        .dec32       (dec32)
    );

    assign wide_mode = cfg.wide;
    assign len16     = cfg.len16;
    assign len32     = cfg.len32;
    assign cnt16     = cfg.cnt16;
    assign cnt32     = cfg.cnt32;
    assign rx_ready  = busy && run_read && slot_full;
    assign tx_req    = busy && !run_read && !slot_full;

endmodule

// File: rtl/dxfer_chk.sv
module dxfer_chk
    import dxfer_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cfg_wr,
    input logic [SEL_W-1:0] cfg_sel,
    input logic             host_rd,
    input logic             host_wr,
    input logic             slot_full,
    input logic             run_wide,
    input logic [LEN_W-1:0] len16,
    input logic [CNT_W-1:0] cnt32,
    input logic             busy,
    input logic             rx_ready,
    input logic             tx_req,
    input logic             data_end,
    input logic             ovf_flag,
    input logic             unf_flag,
    input logic             aux_blk,
    input logic             aux_end
);

    p_len16_ceiling_r2: assert property (@(posedge clk) disable iff (rst)
        len16 <= LEN16_CEIL);

    p_cnt32_steps_r4: assert property (@(posedge clk) disable iff (rst)
        !(cfg_wr && cfg_sel == SEL_CNT32) |=>
            (cnt32 == $past(cnt32)) || (cnt32 == $past(cnt32) - CNT_W'(1)));

    p_handshake_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(rx_ready && tx_req));

    p_handshake_busy_r5: assert property (@(posedge clk) disable iff (rst)
        (rx_ready || tx_req) |-> busy);

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        (host_wr && slot_full) |=> ovf_flag);

    p_no_underrun_r7: assert property (@(posedge clk) disable iff (rst)
        (host_rd && !slot_full) |=> unf_flag);

    p_aux_blk_wide_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(aux_blk) |-> $past(run_wide));

    p_aux_end_wide_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(aux_end) |-> $past(run_wide));

    p_end_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        data_end |=> !data_end);

    p_end_idle_r9: assert property (@(posedge clk) disable iff (rst)
        data_end |-> !busy);

endmodule

bind dxfer_ctrl dxfer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_wr    (cfg_wr),
    .cfg_sel   (cfg_sel),
    .host_rd   (host_rd),
    .host_wr   (host_wr),
    .slot_full (slot_full),
    .run_wide  (run_wide),
    .len16     (len16),
    .cnt32     (cnt32),
    .busy      (busy),
    .rx_ready  (rx_ready),
    .tx_req    (tx_req),
    .data_end  (data_end),
    .ovf_flag  (ovf_flag),
    .unf_flag  (unf_flag),
    .aux_blk   (aux_blk),
    .aux_end   (aux_end)
);

// File: tb/tb_dxfer_ctrl.sv
module tb_dxfer_ctrl;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [15:0] cfg_wdata = '0;
    logic        xfer_start = 1'b0, xfer_read = 1'b0, xfer_multi = 1'b0;
    logic        host_rd = 1'b0, host_wr = 1'b0;
    logic [31:0] host_wdata = '0, host_rdata;
    logic        card_push = 1'b0, card_pop = 1'b0;
    logic [31:0] card_wdata = '0, card_rdata;
    logic        wide_mode;
    logic [9:0]  len16, len32;
    logic [15:0] cnt16, cnt32;
    logic        busy, rx_ready, tx_req, data_end;
    logic        ovf_flag, unf_flag, aux_blk, aux_end;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dxfer_ctrl dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .xfer_start(xfer_start), .xfer_read(xfer_read), .xfer_multi(xfer_multi),
        .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .card_push(card_push), .card_wdata(card_wdata), .card_pop(card_pop), .card_rdata(card_rdata),
        .wide_mode(wide_mode), .len16(len16), .len32(len32), .cnt16(cnt16), .cnt32(cnt32),
        .busy(busy), .rx_ready(rx_ready), .tx_req(tx_req), .data_end(data_end),
        .ovf_flag(ovf_flag), .unf_flag(unf_flag), .aux_blk(aux_blk), .aux_end(aux_end)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] sel, input logic [15:0] val);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic run_xfer(input bit wide, input bit rd, input bit multi, input int len, input int cnt);
        int lc, step, per_blk, blocks, all;
        logic [31:0] mask, pat;
        int exp32;
        bit end_seen_ok;
        reg_write(3'd0, wide ? 16'h0002 : 16'h0000);
        if (wide) reg_write(3'd3, 16'(len)); else reg_write(3'd1, 16'(len));
        reg_write(3'd2, 16'(cnt));
        reg_write(3'd4, 16'(cnt));
        reg_write(3'd5, 16'h0003);
        lc      = wide ? (len & 16'h3FF) : (((len & 16'h3FF) > 512) ? 512 : (len & 16'h3FF));
        step    = wide ? 4 : 2;
        per_blk = (lc == 0) ? 1 : (lc + step - 1) / step;
        blocks  = (multi && cnt > 1) ? cnt : 1;
        all     = per_blk * blocks;
        mask    = wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        chk(wide_mode == wide, "R1 width bit", 32'(wide_mode), 32'(wide));
        xfer_start = 1'b1; xfer_read = rd; xfer_multi = multi;
        @(negedge clk);
        xfer_start = 1'b0;
        end_seen_ok = 1'b1;
        for (int k = 1; k <= all; k++) begin
            pat = {16'(k) ^ 16'hA5C3, 16'(k) + 16'h1234};
            if (rd) begin
                card_push = 1'b1; card_wdata = pat;
                @(negedge clk);
                card_push = 1'b0;
                chk(rx_ready == 1'b1, "R5 rx_ready", 32'(rx_ready), 32'd1);
                chk(host_rdata == (pat & mask), "R12 read mask", host_rdata, pat & mask);
                host_rd = 1'b1;
                @(negedge clk);
                host_rd = 1'b0;
                if (data_end != (k == all)) end_seen_ok = 1'b0;
            end else begin
                chk(tx_req == 1'b1, "R5 tx_req", 32'(tx_req), 32'd1);
                host_wr = 1'b1; host_wdata = pat;
                @(negedge clk);
                host_wr = 1'b0;
                if (data_end != (k == all)) end_seen_ok = 1'b0;
                chk(card_rdata == (pat & mask), "R12 write mask", card_rdata, pat & mask);
                card_pop = 1'b1;
                @(negedge clk);
                card_pop = 1'b0;
            end
        end
        chk(end_seen_ok, "R9 data_end timing", 32'(all), 32'(all));
        chk(busy == 1'b0, "R9 idle after end", 32'(busy), 32'd0);
        exp32 = (wide && multi) ? 0 : cnt;
        chk(cnt32 == 16'(exp32), (multi ? "R4 cnt32 live" : "R10 single keeps cnt32"), 32'(cnt32), 32'(exp32));
        chk(cnt16 == 16'(cnt), "R4 cnt16 untouched", 32'(cnt16), 32'(cnt));
        chk(aux_blk == wide && aux_end == wide, "R8 aux flags", {aux_blk, aux_end}, {wide, wide});
        chk(ovf_flag == 1'b0 && unf_flag == 1'b0, "R6 R7 no error", {ovf_flag, unf_flag}, 32'd0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int lens [6] = '{0, 1, 4, 6, 18, 513};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(len16 == 10'h200 && len32 == 10'h200, "R11 lengths", {len16, len32}, {10'h200, 10'h200});
        chk(cnt16 == 0 && cnt32 == 0 && wide_mode == 0, "R11 counts", {cnt16, cnt32}, 32'd0);
        chk({busy, rx_ready, tx_req, data_end, ovf_flag, unf_flag, aux_blk, aux_end} == 8'd0,
            "R11 flags", {busy, rx_ready, tx_req, data_end, ovf_flag, unf_flag, aux_blk, aux_end}, 32'd0);
        // R2 clipping of 16-bit length
        reg_write(3'd1, 16'h03FF); chk(len16 == 10'h200, "R2 clip 3FF", 32'(len16), 32'h200);
        reg_write(3'd1, 16'h0201); chk(len16 == 10'h200, "R2 clip 201", 32'(len16), 32'h200);
        reg_write(3'd1, 16'h01FF); chk(len16 == 10'h1FF, "R2 keep 1FF", 32'(len16), 32'h1FF);
        reg_write(3'd1, 16'h0200); chk(len16 == 10'h200, "R2 keep 200", 32'(len16), 32'h200);
        // R3 full range of 32-bit length
        reg_write(3'd3, 16'hFFFF); chk(len32 == 10'h3FF, "R3 len32 3FF", 32'(len32), 32'h3FF);
        reg_write(3'd3, 16'h0123); chk(len32 == 10'h123, "R3 len32 123", 32'(len32), 32'h123);
        // Sweep: width x direction x length x count mode (mode 4 = single with count 3)
        for (int w = 0; w < 2; w++)
            for (int d = 0; d < 2; d++)
                for (int li = 0; li < 6; li++)
                    for (int m = 0; m < 5; m++)
                        run_xfer(w[0], d[0], (m < 4), lens[li], (m < 4) ? m : 3);
        // R8 clear of the auxiliary pair (last sweep run was 32-bit)
        reg_write(3'd5, 16'h0001);
        chk(aux_blk == 0 && aux_end == 0, "R8 aux clear", {aux_blk, aux_end}, 32'd0);
        // R7 underrun: host read with empty slot
        host_rd = 1'b1; @(negedge clk); host_rd = 1'b0;
        chk(unf_flag == 1'b1, "R7 underrun set", 32'(unf_flag), 32'd1);
        chk(ovf_flag == 1'b0, "R6 no overflow on read", 32'(ovf_flag), 32'd0);
        reg_write(3'd5, 16'h0002);
        chk(unf_flag == 1'b0, "R7 underrun clear", 32'(unf_flag), 32'd0);
        // R6 overflow: host write with full slot leaves contents
        card_push = 1'b1; card_wdata = 32'hCAFE_0F0F; @(negedge clk); card_push = 1'b0;
        host_wr = 1'b1; host_wdata = 32'h1111_2222; @(negedge clk); host_wr = 1'b0;
        chk(ovf_flag == 1'b1, "R6 overflow set", 32'(ovf_flag), 32'd1);
        chk(card_rdata == 32'hCAFE_0F0F, "R6 slot kept", card_rdata, 32'hCAFE_0F0F);
        host_rd = 1'b1; @(negedge clk); host_rd = 1'b0;
        chk(unf_flag == 1'b0, "R7 no underrun on full read", 32'(unf_flag), 32'd0);
        reg_write(3'd5, 16'h0002);
        chk(ovf_flag == 1'b0, "R6 overflow clear", 32'(ovf_flag), 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule